// File: doc/BRIEF.md
# Halfword-Swapping DMA Memory Port

This block sits between a network peripheral that has a 16-bit data bus and a 32-bit system memory interface. The peripheral asks for a transfer by giving a read or write direction, an address relative to its own window, a byte length and a flag that turns off byte swapping. The block builds the system address by ORing the request address with a base address register, then issues one or more commands on a valid/ready command channel toward memory.

In swap mode the block clears bit 0 of the formed address and of the length, so the transfer covers whole halfwords. It also exchanges the two bytes of each 16-bit halfword on the write data path (peripheral to memory) and on the read data path (memory to peripheral). Swapped writes are cut into chunks of at most 64 bytes. Each later chunk starts at the previous chunk address plus the previous chunk length. Reads, and writes in bypass mode, go out as one command that carries the whole length. A single `done` pulse marks the end of a transfer, and `busy` shows when a new request would be refused.

Top module: `hswap_dma_port`

## Requirements
- R1: After reset `busy`, `done` and `mem_cmd_valid` are 0, and `mem_cmd_valid` is never 1 while `busy` is 0.
- R2: The first command address equals `req_addr` bitwise-ORed with the base register value most recently written through `base_we`/`base_wdata`. Later chunks add the chunk length to this address and do not apply the OR again.
- R3: With `req_bypass`=1 the command address and length are exactly as formed and requested, and data passes unchanged in both directions.
- R4: With `req_bypass`=0, bit 0 of the formed address and bit 0 of the length are cleared before the first command.
- R5: With `req_bypass`=0, data byte lanes [7:0] and [15:8] are exchanged in every halfword, on `pd_wdata`→`mem_wdata` and on `mem_rdata`→`pd_rdata`.
- R6: A swapped write is issued as commands of at most 64 bytes. Each command takes min(remaining, 64) bytes, and the next address is the current address plus that length.
- R7: A read, or a bypass write, is issued as a single command that carries the full length.
- R8: A request whose effective length is 0 produces no command, and `done` is 1 in the cycle after acceptance with `busy` staying 0.
- R9: While `mem_cmd_valid`=1 and `mem_cmd_ready`=0, the command stays valid with unchanged address and length.
- R10: `done` is a one-cycle pulse in the cycle after the last command is accepted. In that same cycle `busy` has returned to 0.
- R11: A request presented while `busy`=1 is ignored. It changes neither the current command nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the base address register |
| base_wdata | input | AW | New base address value |
| req_valid | input | 1 | Transfer request strobe, taken when not busy |
| req_write | input | 1 | 1 = write to memory, 0 = read from memory |
| req_bypass | input | 1 | 1 = no swap and no alignment |
| req_addr | input | AW | Peripheral-relative byte address |
| req_len | input | LW | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | Command direction |
| mem_cmd_addr | output | AW | Command byte address |
| mem_cmd_len | output | LW | Command byte length |
| pd_wdata | input | DW | Write data from the peripheral |
| mem_wdata | output | DW | Write data toward memory |
| mem_rdata | input | DW | Read data from memory |
| pd_rdata | output | DW | Read data toward the peripheral |

## Verification
The first command of a request appears one clock after the edge that accepts it. Each following chunk appears one clock after the edge at which `mem_cmd_ready` took the previous one. `done` arrives one clock after the edge that takes the last chunk, or one clock after acceptance when the effective length is zero. The data lanes are combinational from the latched mode, so they are valid in the same cycle. Inputs are driven just after a falling edge and every output is read at the following falling edge, so each check falls exactly on the cycle these counts give.

// File: rtl/hswap_pkg.sv
package hswap_pkg;

    localparam int HSW_AW_DEF    = 32;
    localparam int HSW_LW_DEF    = 16;
    localparam int HSW_DW_DEF    = 32;
    localparam int HSW_CHUNK_DEF = 64;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic write;
        logic bypass;
    } xfer_mode_t;

    function automatic logic is_split(input xfer_mode_t m);
        return m.write && !m.bypass;
    endfunction

endpackage

// File: rtl/hswap_addr_form.sv
module hswap_addr_form #(
    parameter int AW = hswap_pkg::HSW_AW_DEF,
    parameter int LW = hswap_pkg::HSW_LW_DEF
) (
    input  logic [AW-1:0] raw_addr,
    input  logic [LW-1:0] raw_len,
    input  logic [AW-1:0] base,
    input  logic          bypass,
    output logic [AW-1:0] eff_addr,
    output logic [LW-1:0] eff_len
);
    logic [AW-1:0] ored;

    always_comb begin
        ored     = raw_addr | base;
        eff_addr = ored;
        eff_len  = raw_len;
        if (!bypass) begin
            eff_addr[0] = 1'b0;
            eff_len[0]  = 1'b0;
        end
    end
endmodule

// File: rtl/hswap_lane.sv
module hswap_lane #(
    parameter int DW = hswap_pkg::HSW_DW_DEF
) (
    input  logic [DW-1:0] din,
    input  logic          bypass,
    output logic [DW-1:0] dout
);
    localparam int NHW = DW / 16;

    logic [DW-1:0] swapped;

    genvar g;
    generate
        for (g = 0; g < NHW; g++) begin : g_hw
            assign swapped[16*g +: 8]     = din[16*g + 8 +: 8];
            assign swapped[16*g + 8 +: 8] = din[16*g +: 8];
        end
    endgenerate

    assign dout = bypass ? din : swapped;
endmodule

// File: rtl/hswap_chunker.sv
module hswap_chunker
    import hswap_pkg::*;
#(
    parameter int AW          = HSW_AW_DEF,
    parameter int LW          = HSW_LW_DEF,
    parameter int CHUNK_BYTES = HSW_CHUNK_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [LW-1:0]    start_len,
    input  xfer_mode_t       start_mode,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [AW-1:0]    cmd_addr,
    output logic [LW-1:0]    cmd_len,
    output logic             cmd_write,
    output logic             busy,
    output logic             done,
    output xfer_mode_t       mode
);
    localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK_BYTES);

    seq_state_t    st_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    xfer_mode_t    mode_q;
    logic          done_q;
    logic          last;

    always_comb begin
        if (is_split(mode_q) && (rem_q > CHUNK_L)) begin
            cmd_len = CHUNK_L;
        end else begin
            cmd_len = rem_q;
        end
        last = (rem_q == cmd_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            rem_q  <= '0;
            mode_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= start_mode;
                        addr_q <= start_addr;
                        rem_q  <= start_len;
                        if (start_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (cmd_ready) begin
                        addr_q <= addr_q + AW'(cmd_len);
                        rem_q  <= rem_q - cmd_len;
                        if (last) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_valid = (st_q == ST_RUN);
    assign cmd_addr  = addr_q;
    assign cmd_write = mode_q.write;
    assign busy      = (st_q == ST_RUN);
    assign done      = done_q;
    assign mode      = mode_q;
endmodule

// File: rtl/hswap_dma_port.sv
module hswap_dma_port
    import hswap_pkg::*;
#(
    parameter int AW          = HSW_AW_DEF,
    parameter int LW          = HSW_LW_DEF,
    parameter int DW          = HSW_DW_DEF,
    parameter int CHUNK_BYTES = HSW_CHUNK_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_bypass,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          busy,
    output logic          done,
    output logic          mem_cmd_valid,
    input  logic          mem_cmd_ready,
    output logic          mem_cmd_write,
    output logic [AW-1:0] mem_cmd_addr,
    output logic [LW-1:0] mem_cmd_len,
    input  logic [DW-1:0] pd_wdata,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] pd_rdata
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] form_addr;
    logic [LW-1:0] form_len;
    logic          start;
    xfer_mode_t    req_mode;
    xfer_mode_t    cur_mode;
    logic          cur_bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= base_wdata;
        end
    end

    assign req_mode.write  = req_write;
    assign req_mode.bypass = req_bypass;
    assign start           = req_valid && !busy;

    hswap_addr_form #(.AW(AW), .LW(LW)) u_form (
        .raw_addr (req_addr),
        .raw_len  (req_len),
        .base     (base_q),
        .bypass   (req_bypass),
        .eff_addr (form_addr),
        .eff_len  (form_len)
    );

    hswap_chunker #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (form_addr),
        .start_len  (form_len),
        .start_mode (req_mode),
        .cmd_ready  (mem_cmd_ready),
        .cmd_valid  (mem_cmd_valid),
        .cmd_addr   (mem_cmd_addr),
        .cmd_len    (mem_cmd_len),
        .cmd_write  (mem_cmd_write),
        .busy       (busy),
        .done       (done),
        .mode       (cur_mode)
    );

    assign cur_bypass = cur_mode.bypass;

    hswap_lane #(.DW(DW)) u_wlane (
        .din    (pd_wdata),
        .bypass (cur_bypass),
        .dout   (mem_wdata)
    );

    hswap_lane #(.DW(DW)) u_rlane (
        .din    (mem_rdata),
        .bypass (cur_bypass),
        .dout   (pd_rdata)
    );
endmodule

// File: rtl/hswap_dma_port_chk.sv
module hswap_dma_port_chk #(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          mem_cmd_valid,
    input logic          mem_cmd_ready,
    input logic          mem_cmd_write,
    input logic [AW-1:0] mem_cmd_addr,
    input logic [LW-1:0] mem_cmd_len,
    input logic          cur_bypass
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_cmd_valid); // R1
    AST_EVEN_SWAP: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !cur_bypass) |-> (!mem_cmd_addr[0] && !mem_cmd_len[0])); // R4
    AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_write && !cur_bypass) |-> (mem_cmd_len <= LW'(CHUNK_BYTES))); // R6
    AST_NONZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> (mem_cmd_len != '0)); // R8
    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len))); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_cmd_valid)); // R10
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_cmd_valid && mem_cmd_ready) || $past(req_valid && !busy))); // R10
endmodule

bind hswap_dma_port hswap_dma_port_chk #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_write (mem_cmd_write),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_cmd_len   (mem_cmd_len),
    .cur_bypass    (cur_bypass)
);

// File: tb/tb_hswap_dma_port.sv
`timescale 1ns/1ps
module tb_hswap_dma_port;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          base_we;
    logic [AW-1:0] base_wdata;
    logic          req_valid, req_write, req_bypass;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic          busy, done;
    logic          mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [LW-1:0] mem_cmd_len;
    logic [DW-1:0] pd_wdata, mem_wdata, mem_rdata, pd_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hswap_dma_port dut (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_bypass(req_bypass),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_len(mem_cmd_len), .pd_wdata(pd_wdata), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pd_rdata(pd_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [AW-1:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // drives a request for one cycle; returns at the following falling edge
    task automatic issue(input logic wr, input logic byp, input logic [AW-1:0] a, input logic [LW-1:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bypass = byp; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 cmd_valid after reset", 64'(mem_cmd_valid), 64'd0);
    endtask

    task automatic t_bypass_write();
        set_base(32'h1000_0000);
        issue(1'b1, 1'b1, 32'h0000_0123, 16'd7);
        chk("R2 R3 bypass addr", 64'(mem_cmd_addr), 64'h1000_0123);
        chk("R3 bypass len odd kept", 64'(mem_cmd_len), 64'd7);
        chk("R7 bypass write one cmd valid", 64'(mem_cmd_valid), 64'd1);
        pd_wdata = 32'h1122_3344; mem_rdata = 32'hAABB_CCDD;
        #0.1;
        chk("R3 bypass wdata", 64'(mem_wdata), 64'h1122_3344);
        chk("R3 bypass rdata", 64'(pd_rdata), 64'hAABB_CCDD);
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        chk("R7 R10 done after single cmd", 64'(done), 64'd1);
        chk("R10 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R10 done is one pulse", 64'(done), 64'd0);
    endtask

    task automatic t_swap_write_chunks();
        set_base(32'h2000_0001);
        issue(1'b1, 1'b0, 32'h0000_0040, 16'd151);
        chk("R2 R4 first chunk addr", 64'(mem_cmd_addr), 64'h2000_0040);
        chk("R6 first chunk len", 64'(mem_cmd_len), 64'd64);
        pd_wdata = 32'h1122_3344; mem_rdata = 32'hAABB_CCDD;
        #0.1;
        chk("R5 swapped wdata", 64'(mem_wdata), 64'h2211_4433);
        chk("R5 swapped rdata", 64'(pd_rdata), 64'hBBAA_DDCC);
        @(negedge clk);
        chk("R9 held addr", 64'(mem_cmd_addr), 64'h2000_0040);
        chk("R9 held valid", 64'(mem_cmd_valid), 64'd1);
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        chk("R6 second chunk addr", 64'(mem_cmd_addr), 64'h2000_0080);
        chk("R6 second chunk len", 64'(mem_cmd_len), 64'd64);
        @(negedge clk);
        chk("R6 third chunk addr", 64'(mem_cmd_addr), 64'h2000_00C0);
        chk("R4 R6 third chunk len", 64'(mem_cmd_len), 64'd22);
        chk("R10 no done mid transfer", 64'(done), 64'd0);
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        chk("R10 done after last chunk", 64'(done), 64'd1);
        chk("R10 cmd_valid low at done", 64'(mem_cmd_valid), 64'd0);
    endtask

    task automatic t_swap_read();
        set_base(32'h0000_0000);
        issue(1'b0, 1'b0, 32'h0000_0003, 16'd200);
        chk("R4 read addr even", 64'(mem_cmd_addr), 64'h2);
        chk("R7 read single len", 64'(mem_cmd_len), 64'd200);
        chk("R7 read direction", 64'(mem_cmd_write), 64'd0);
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        chk("R7 read done after one cmd", 64'(done), 64'd1);
    endtask

    task automatic t_zero_len();
        issue(1'b1, 1'b0, 32'h0000_0005, 16'd1);
        chk("R8 done at once", 64'(done), 64'd1);
        chk("R8 no command", 64'(mem_cmd_valid), 64'd0);
        chk("R8 never busy", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R8 done one pulse", 64'(done), 64'd0);
        chk("R8 still no command", 64'(mem_cmd_valid), 64'd0);
    endtask

    task automatic t_busy_ignore();
        issue(1'b1, 1'b1, 32'h0000_0100, 16'd8);
        req_valid = 1'b1; req_addr = 32'h0000_0900; req_len = 16'd4; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 addr unchanged", 64'(mem_cmd_addr), 64'h100);
        chk("R11 len unchanged", 64'(mem_cmd_len), 64'd8);
        chk("R11 direction unchanged", 64'(mem_cmd_write), 64'd1);
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        chk("R11 done", 64'(done), 64'd1);
        @(negedge clk);
        chk("R11 no late command", 64'(mem_cmd_valid), 64'd0);
        chk("R11 not busy", 64'(busy), 64'd0);
    endtask

    initial begin
        rst = 1'b1; base_we = 1'b0; base_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_bypass = 1'b0;
        req_addr = '0; req_len = '0; mem_cmd_ready = 1'b0;
        pd_wdata = '0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass_write();
        t_swap_write_chunks();
        t_swap_read();
        t_zero_len();
        t_busy_ignore();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule